// File: doc/BRIEF.md
# SPI Command Layer for a Serial Port

This block is the host-facing control logic of a UART that a processor reaches over SPI. Every transaction is one 16-bit full-duplex frame. The host shifts a command in on `din_i` and receives a status or data word on `dout_o` during the same frame. The two leading bits of each frame pick one of four operations: write configuration, read configuration, write data or read data. On the far side the block drives plain handshake strobes to a transmit shifter and to a receive FIFO. The baud generator and line interface are outside the block.

The SPI pins are brought into the `clk_i` domain through synchronizer flops. All register updates are therefore synchronous to the system clock, and `clk_i` must run well above the SPI clock rate.

The interrupt masks take effect as soon as the 16th bit of a configuration frame is in. The remaining configuration fields are held back until chip select has risen and the transmitter is idle. This keeps a frame that is on the line from changing format mid-character. A write-data frame can set the RTS output without queueing a byte.

Top module: `uart_spi_ctrl`

## Requirements
- R1: A frame takes effect only after its 16th SCLK rising edge, with DIN sampled MSB first. Bits 15:14 select the operation: 11 write config, 01 read config, 10 write data, 00 read data. A frame that ends before 16 clocks changes nothing.
- R2: DOUT is updated after SCLK falling edges. Bit 15 of every reply is the receive-ready flag and bit 14 is the transmit-empty flag, both taken when CS falls.
- R3: The four mask bits of a config write apply right after the 16th clock. Bit 11 masks transmit-empty, bit 10 receive-ready, bit 9 received parity and bit 8 framing error. They apply even while the transmitter is busy.
- R4: The other config fields take effect only once CS is high and the transmitter is idle (transmit-empty set and `tx_busy_i` low). These fields are bit 13 FIFO disable, bit 12 shutdown, bit 7 IrDA, bit 6 stop bits, bit 5 parity enable, bit 4 word length and bits 3:0 baud select. They appear on `cfg_o` as {b13,b12,b7,b6,b5,b4,b3:0}.
- R5: A config write pulses `fifo_clr_o` once. A read-config reply returns bits 13:1 of the last config written, and bit 0 of the reply is the test-mode flag.
- R6: A write-data frame always copies bit 9 to RTS. When bit 10 is 0, it pulses `tx_load_o`, presents bits 8:0 on `tx_data_o` and clears transmit-empty. When bit 10 is 1, no byte is loaded.
- R7: A read-data reply carries framing error in bit 10, CTS in bit 9, received parity in bit 8 and the byte in bits 7:0. If receive-ready was set, completing the frame pulses `rx_pop_o`.
- R8: `irq_no` is low exactly when some masked condition holds: transmit-empty, receive-ready, or receive-ready with parity or framing error.
- R9: After reset, `cfg_o` and the masks are zero, RTS is low, transmit-empty is 1 and `irq_no` is high.
- R10: A read-config frame with DIN bit 0 set enters test mode, and one with bit 0 clear leaves it. In test mode `loop_o` is high, and `rts_o` follows `baud16_i` while CS is low.
- R11: A `tx_taken_i` pulse sets transmit-empty again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock |
| cs_ni | input | 1 | SPI chip select, active low |
| din_i | input | 1 | SPI data from host |
| dout_o | output | 1 | SPI data to host |
| tx_busy_i | input | 1 | Transmit shifter is sending a character |
| tx_taken_i | input | 1 | Shifter took the buffered byte |
| tx_load_o | output | 1 | Strobe: new byte on tx_data_o |
| tx_data_o | output | 9 | Parity/ninth bit and data byte |
| rx_avail_i | input | 1 | Receive FIFO holds a byte |
| rx_data_i | input | 8 | Byte at FIFO head |
| rx_par_i | input | 1 | Parity bit at FIFO head |
| rx_fe_i | input | 1 | Framing error at FIFO head |
| rx_pop_o | output | 1 | Strobe: remove FIFO head |
| fifo_clr_o | output | 1 | Strobe: empty the FIFO |
| cts_i | input | 1 | Clear-to-send input state |
| baud16_i | input | 1 | 16x baud clock for test output |
| rts_o | output | 1 | Request-to-send output |
| loop_o | output | 1 | Test mode: loop TX to RX |
| cfg_o | output | 10 | Applied configuration fields |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench targets the deferred configuration path by writing a config while `tx_busy_i` is high. A design that applied every field at once would change `cfg_o` mid-character. A design that deferred the masks as well would leave `irq_no` high. Truncated frames are driven to catch a design that acts on a partial command, for example by loading a byte or moving RTS. Write-data frames with the inhibit bit check that RTS still moves while no load strobe appears. Read-data and read-config replies are compared bit by bit, which exposes a misordered DOUT shift or status bits taken at the wrong time.

// File: rtl/uart_spi_pkg.sv
package uart_spi_pkg;
  localparam int FRAME_W = 16;
  localparam int CFG_W   = 10;

  typedef enum logic [1:0] {
    OP_RD_DATA = 2'b00,
    OP_RD_CFG  = 2'b01,
    OP_WR_DATA = 2'b10,
    OP_WR_CFG  = 2'b11
  } op_e;

  typedef struct packed {
    logic       fifo_off;
    logic       shdn;
    logic       irda;
    logic       stop2;
    logic       par_en;
    logic       wlen;
    logic [3:0] baud;
  } cfg_t;
endpackage

// File: rtl/uart_spi_front.sv
module uart_spi_front #(
  parameter int FRAME_W = 16,
  parameter int SYNC_N  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               din_i,
  input  logic [FRAME_W-1:0] resp_i,
  output logic               dout_o,
  output logic               start_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [1:0]         op_o,
  output logic               cs_high_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int IDX_W = $clog2(FRAME_W);

  logic [SYNC_N-1:0] sclk_s, cs_s, din_s;
  logic sclk_q, cs_q, start_d, dout_q;
  logic sclk, cs, din, rise, fall;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic [IDX_W-1:0]   bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      cs_s   <= '1;
      din_s  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC_N-2:0], sclk_i};
      cs_s   <= {cs_s[SYNC_N-2:0], cs_ni};
      din_s  <= {din_s[SYNC_N-2:0], din_i};
      sclk_q <= sclk;
      cs_q   <= cs;
    end
  end

  assign sclk    = sclk_s[SYNC_N-1];
  assign cs      = cs_s[SYNC_N-1];
  assign din     = din_s[SYNC_N-1];
  assign rise    = sclk & ~sclk_q & ~cs;
  assign fall    = ~sclk & sclk_q & ~cs;
  assign start_o = ~cs & cs_q;
  assign bit_idx = IDX_W'(FRAME_W - 1) - cnt[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt     <= '0;
      sh      <= '0;
      op_o    <= '0;
      done_o  <= 1'b0;
      frame_o <= '0;
      start_d <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      start_d <= start_o;
      if (start_o) begin
        cnt <= '0;
        sh  <= '0;
      end else if (rise && cnt < CNT_W'(FRAME_W)) begin
        sh  <= {sh[FRAME_W-2:0], din};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(1)) op_o <= {sh[0], din};
        if (cnt == CNT_W'(FRAME_W - 1)) begin
          done_o  <= 1'b1;
          frame_o <= {sh[FRAME_W-2:0], din};
        end
      end
      if (cs)                dout_q <= 1'b0;
      else if (start_d)      dout_q <= resp_i[FRAME_W-1];
      else if (fall)         dout_q <= (cnt < CNT_W'(FRAME_W)) ? resp_i[bit_idx] : 1'b0;
    end
  end

  assign dout_o    = dout_q;
  assign cs_high_o = cs;

  assert_done_in_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cnt) == CNT_W'(FRAME_W - 1) && !$past(cs));
  assert_idle_dout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs) && cs |-> !dout_o);
endmodule

// File: rtl/uart_spi_regs.sv
module uart_spi_regs
  import uart_spi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [1:0]         op_i,
  input  logic               cs_high_i,
  output logic [FRAME_W-1:0] resp_o,
  input  logic               tx_busy_i,
  input  logic               tx_taken_i,
  output logic               tx_load_o,
  output logic [8:0]         tx_data_o,
  input  logic               rx_avail_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_par_i,
  input  logic               rx_fe_i,
  output logic               rx_pop_o,
  output logic               fifo_clr_o,
  input  logic               cts_i,
  input  logic               baud16_i,
  output logic               rts_o,
  output logic               loop_o,
  output logic [CFG_W-1:0]   cfg_o,
  output logic               irq_no
);
  cfg_t        cfg_q, pend_q;
  logic        pend_v, t_q, rts_q, test_q;
  logic [3:0]  mask_q;
  logic [13:0] last_q;
  logic        r_s, t_s;
  logic [10:0] d_s;
  logic        tx_idle;
  op_e         op;

  assign op      = op_e'(op_i);
  assign tx_idle = t_q & ~tx_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_s <= 1'b0;
      t_s <= 1'b1;
      d_s <= '0;
    end else if (start_i) begin
      r_s <= rx_avail_i;
      t_s <= t_q;
      d_s <= {rx_fe_i, cts_i, rx_par_i, rx_data_i};
    end
  end

  always_comb begin
    resp_o = '0;
    resp_o[15] = r_s;
    resp_o[14] = t_s;
    case (op)
      OP_RD_DATA: resp_o[10:0] = d_s;
      OP_RD_CFG:  resp_o[13:0] = {last_q[13:1], test_q};
      default:    ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      pend_q     <= '0;
      pend_v     <= 1'b0;
      mask_q     <= '0;
      last_q     <= '0;
      t_q        <= 1'b1;
      rts_q      <= 1'b0;
      test_q     <= 1'b0;
      tx_load_o  <= 1'b0;
      tx_data_o  <= '0;
      rx_pop_o   <= 1'b0;
      fifo_clr_o <= 1'b0;
    end else begin
      tx_load_o  <= 1'b0;
      rx_pop_o   <= 1'b0;
      fifo_clr_o <= 1'b0;
      if (tx_taken_i) t_q <= 1'b1;
      if (done_i) begin
        case (op_e'(frame_i[15:14]))
          OP_WR_CFG: begin
            mask_q     <= frame_i[11:8];
            last_q     <= frame_i[13:0];
            pend_q     <= {frame_i[13:12], frame_i[7:0]};
            pend_v     <= 1'b1;
            fifo_clr_o <= 1'b1;
          end
          OP_RD_CFG: test_q <= frame_i[0];
          OP_WR_DATA: begin
            rts_q <= frame_i[9];
            if (!frame_i[10]) begin
              tx_load_o <= 1'b1;
              tx_data_o <= frame_i[8:0];
              t_q       <= 1'b0;
            end
          end
          OP_RD_DATA: rx_pop_o <= r_s;
          default: ;
        endcase
      end else if (pend_v && cs_high_i && tx_idle) begin
        cfg_q  <= pend_q;
        pend_v <= 1'b0;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign loop_o = test_q;
  assign rts_o  = (test_q && !cs_high_i) ? baud16_i : rts_q;
  assign irq_no = ~|(mask_q & {t_q, rx_avail_i, rx_avail_i & rx_par_i, rx_avail_i & rx_fe_i});

  assert_cfg_defer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(cs_high_i && !tx_busy_i && t_q));
  assert_load_clears_t_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> !t_q);
  assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_load_o, rx_pop_o, fifo_clr_o}));
  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == 4'b0 |-> irq_no);
  assert_pop_had_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> $past(r_s));
endmodule

// File: rtl/uart_spi_ctrl.sv
module uart_spi_ctrl
  import uart_spi_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             din_i,
  output logic             dout_o,
  input  logic             tx_busy_i,
  input  logic             tx_taken_i,
  output logic             tx_load_o,
  output logic [8:0]       tx_data_o,
  input  logic             rx_avail_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_par_i,
  input  logic             rx_fe_i,
  output logic             rx_pop_o,
  output logic             fifo_clr_o,
  input  logic             cts_i,
  input  logic             baud16_i,
  output logic             rts_o,
  output logic             loop_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             irq_no
);
  logic               start, done, cs_high;
  logic [FRAME_W-1:0] frame, resp;
  logic [1:0]         op;

  uart_spi_front #(.FRAME_W(FRAME_W), .SYNC_N(SYNC_N)) u_front (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .din_i,
    .resp_i(resp), .dout_o, .start_o(start), .done_o(done),
    .frame_o(frame), .op_o(op), .cs_high_o(cs_high)
  );

  uart_spi_regs u_regs (
    .clk_i, .rst_ni, .start_i(start), .done_i(done), .frame_i(frame),
    .op_i(op), .cs_high_i(cs_high), .resp_o(resp),
    .tx_busy_i, .tx_taken_i, .tx_load_o, .tx_data_o,
    .rx_avail_i, .rx_data_i, .rx_par_i, .rx_fe_i, .rx_pop_o, .fifo_clr_o,
    .cts_i, .baud16_i, .rts_o, .loop_o, .cfg_o, .irq_no
  );
endmodule

// File: tb/uart_spi_ctrl_tb.sv
module uart_spi_ctrl_tb;
  localparam int HP = 8;

  logic clk = 0, rst_ni = 0;
  logic sclk = 0, cs_n = 1, din = 0;
  logic tx_busy = 0, tx_taken = 0, rx_avail = 0, rx_par = 0, rx_fe = 0, cts = 0, baud16 = 0;
  logic [7:0] rx_data = 0;
  logic dout, tx_load, rx_pop, fifo_clr, rts, loop_m, irq_n;
  logic [8:0] tx_data;
  logic [9:0] cfg;

  int n_vec = 0, n_bad = 0;
  int n_load = 0, n_pop = 0, n_clr = 0;
  logic [15:0] r;

  always #2.5 clk = ~clk;

  uart_spi_ctrl u_dut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .cs_ni(cs_n), .din_i(din), .dout_o(dout),
    .tx_busy_i(tx_busy), .tx_taken_i(tx_taken), .tx_load_o(tx_load), .tx_data_o(tx_data),
    .rx_avail_i(rx_avail), .rx_data_i(rx_data), .rx_par_i(rx_par), .rx_fe_i(rx_fe),
    .rx_pop_o(rx_pop), .fifo_clr_o(fifo_clr), .cts_i(cts), .baud16_i(baud16),
    .rts_o(rts), .loop_o(loop_m), .cfg_o(cfg), .irq_no(irq_n)
  );

  always @(posedge clk) begin
    if (tx_load)  n_load++;
    if (rx_pop)   n_pop++;
    if (fifo_clr) n_clr++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] rd);
    rd = '0;
    cs_n = 0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      din = w[15-i];
      repeat (HP) @(negedge clk);
      rd[15-i] = dout;
      sclk = 1;
      repeat (HP) @(negedge clk);
      sclk = 0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 irq", irq_n, 1);
    check("R9 cfg", cfg, 0);
    check("R9 rts", rts, 0);
    check("R9 loop", loop_m, 0);

    xfer(16'h4000, 16, r);
    check("R2 R9 status after reset", r, 16'h4000);

    // R4 R5 config write while idle
    xfer(16'hE02A, 16, r);
    check("R2 reply to config write", r, 16'h4000);
    check("R4 cfg applied when idle", cfg, 10'h22A);
    check("R5 fifo clear pulse", n_clr, 1);
    check("R8 no masks, no irq", irq_n, 1);

    xfer(16'h4000, 16, r);
    check("R5 read config", r, 16'h602A);

    // R3 R4 masks immediate, fields deferred
    tx_busy = 1;
    xfer(16'hC843, 16, r);
    check("R3 mask active while busy", irq_n, 0);
    check("R4 cfg held while busy", cfg, 10'h22A);
    tx_busy = 0;
    repeat (5) @(negedge clk);
    check("R4 cfg applied after tx done", cfg, 10'h043);

    // R6 load
    xfer(16'h835C, 16, r);
    check("R6 load count", n_load, 1);
    check("R6 tx data", tx_data, 9'h15C);
    check("R6 rts set", rts, 1);
    check("R8 tx-empty cleared, irq off", irq_n, 1);
    xfer(16'h4000, 16, r);
    check("R2 T flag clear in reply", r, 16'h0842);

    // R6 inhibit
    xfer(16'h8400, 16, r);
    check("R6 inhibit no load", n_load, 1);
    check("R6 inhibit rts moves", rts, 0);

    // R1 short frames
    xfer(16'h82FF, 8, r);
    check("R1 short write data ignored load", n_load, 1);
    check("R1 short write data ignored rts", rts, 0);
    xfer(16'hC000, 12, r);
    check("R1 short config ignored", n_clr, 2);
    check("R1 short config cfg", cfg, 10'h043);

    // R11
    tx_taken = 1;
    @(negedge clk);
    tx_taken = 0;
    repeat (2) @(negedge clk);
    check("R11 tx taken sets empty", irq_n, 0);

    // R7 read data
    rx_avail = 1; rx_data = 8'hA5; rx_par = 1; rx_fe = 0; cts = 1;
    xfer(16'h0000, 16, r);
    check("R7 read data reply", r, 16'hC3A5);
    check("R7 pop", n_pop, 1);
    rx_avail = 0;

    // R8 receive mask
    xfer(16'hC400, 16, r);
    check("R5 clear count", n_clr, 3);
    repeat (2) @(negedge clk);
    check("R8 rx mask idle", irq_n, 1);
    rx_avail = 1;
    @(negedge clk);
    check("R8 rx mask asserts", irq_n, 0);
    rx_avail = 0;
    @(negedge clk);
    check("R8 rx mask releases", irq_n, 1);

    // R10 test mode
    xfer(16'h8600, 16, r);
    check("R6 rts only", rts, 1);
    xfer(16'h4001, 16, r);
    check("R10 loop on", loop_m, 1);
    cs_n = 0;
    baud16 = 0;
    repeat (5) @(negedge clk);
    check("R10 rts follows baud low", rts, 0);
    baud16 = 1;
    @(negedge clk);
    check("R10 rts follows baud high", rts, 1);
    baud16 = 0;
    cs_n = 1;
    repeat (5) @(negedge clk);
    check("R10 rts back to register", rts, 1);
    xfer(16'h4000, 16, r);
    check("R10 reply shows test flag", r, 16'h4401);
    check("R10 loop off", loop_m, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule